// File: doc/BRIEF.md
# Second-Level Cache Tag Store with Direct Test Access

This block keeps the tags, per-line coherence states and replacement ages of a four-way set-associative second-level cache, together with a small data array. Each tag entry covers a sector of two lines. Each of the two lines has its own two-bit MESI state. Each way of a set carries a two-bit age rank, and the ranks decide which way is replaced. A lookup port compares an address against the four ways of its set. It reports hit, way and line state one cycle later, refreshes the ages, and can allocate a line on a miss.

A second port gives software direct access to everything through one packed 32-bit location word. A bit in that word selects tag space or data space, and further fields pick the way, set, line, octet and dword. Writes take their payload from a data-in word. Reads deliver their result in a data-out word one cycle later. Tag reads return the tag, both line states and all four age ranks of the set in one word. The set count is a parameter (`SET_BITS`, 10 for 1024 sets, smaller for simulation).

Top module: `l2t_array`

## Requirements
- R1: After reset every line of every set is invalid (state 00), and the ages of each set are way n = n. A lookup after reset misses.
- R2: When location bit 20 is 1, the test port addresses tag space. Way is bits 17:16 and set is bits 15:6 (low `SET_BITS` used). The tag word holds tag in bits 31:14, Line1 state in 11:10, Line0 state in 9:8, and the age of way n in bits 2n+1:2n, with bits 13:12 reading 0. A tag write stores the tag and both states of that way and the ages of all four ways of the set. A read returns the stored word on `tp_rdata` one cycle later.
- R3: When location bit 20 is 0, the test port addresses the data array. Way is bits 17:16, set is bits 15:6, the line is bit 5 (1 = Line1), the octet is bits 4:3 and the dword is bit 2 (1 = upper). A data write stores `tp_wdata`, and a read returns it one cycle later.
- R4: States are M=11, E=10, S=01, I=00. A lookup hits when a way's tag equals address bits 31:14 and the line picked by address bit 5 is not I. `lk_hit`, `lk_way` and `lk_state` report this one cycle after `lk_en`.
- R5: On a hit the hit way's age becomes 00. Every way whose age was below the hit way's old age is incremented by one. The others are unchanged.
- R6: A miss with `lk_alloc` low changes nothing and reports hit 0, way 0, state 00.
- R7: A miss with `lk_alloc` high and no tag match picks the lowest way with both lines invalid, otherwise the way with age 11. It writes the tag, sets the addressed line to `lk_fill` and the other line to I, reports that way with `lk_state` = `lk_fill`, and ages the set as in R5.
- R8: A miss with `lk_alloc` high whose tag matches a way that has a valid line fills the addressed line of that same way. The tag and the other line's state are kept.
- R9: Ages written through the test port are stored exactly as given, even when they are not four distinct values.
- R10: When a tag write and a lookup address the same set in the same cycle, the lookup reports from the old contents. The test write alone is stored, and the lookup's update to that set is dropped. When the sets differ, both take effect.
- R11: `lk_ack` is high exactly in the cycle after `lk_en`. `tp_rdata` changes only after a test-port read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tp_en | input | 1 | Test-port access strobe |
| tp_we | input | 1 | Test-port write (1) or read (0) |
| tp_loc | input | 32 | Packed location word |
| tp_wdata | input | 32 | Test-port write payload |
| tp_rdata | output | 32 | Test-port read result |
| lk_en | input | 1 | Lookup strobe |
| lk_addr | input | 32 | Lookup address |
| lk_alloc | input | 1 | Allocate on miss |
| lk_fill | input | 2 | State given to an allocated line |
| lk_ack | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| lk_way | output | 2 | Hit or allocated way |
| lk_state | output | 2 | State of the addressed line |

## Verification
A test-port tag write and a lookup can land in the same cycle. The bench provokes this with one task that drives both strobes together. In one run they address the same set: the lookup must report the old hit and way, and a read-back of the set must show only the written ages and tag. In a second run they address different sets, and both the refreshed ages of the looked-up set and the written entry of the other set must be read back.

// File: rtl/l2t_pkg.sv
package l2t_pkg;
  localparam int WAYS     = 4;
  localparam int WAY_W    = 2;
  localparam int TAG_W    = 18;
  localparam int TAG_LSB  = 14;
  localparam int SET_LSB  = 6;
  localparam int SEL_BIT  = 20;
  localparam int WAY_LSB  = 16;
  localparam int LINE_BIT = 5;
  localparam int OCT_LSB  = 3;
  localparam int DW_BIT   = 2;
  localparam int AGES_W   = 2 * WAYS;

  // line coherence encodings
  localparam logic [1:0] ST_I = 2'b00;
  localparam logic [1:0] ST_S = 2'b01;
  localparam logic [1:0] ST_E = 2'b10;
  localparam logic [1:0] ST_M = 2'b11;

  // {line1 state, line0 state}
  typedef struct packed {
    logic [1:0] l1;
    logic [1:0] l0;
  } pair_t;
endpackage

// File: rtl/l2t_age_update.sv
module l2t_age_update
  import l2t_pkg::*;
(
  input  logic [AGES_W-1:0] ages_i,
  input  logic [WAY_W-1:0]  way_i,
  output logic [AGES_W-1:0] ages_o
);
  logic [1:0] pivot;
  assign pivot = ages_i[2*way_i +: 2];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [1:0] cur;
    assign cur = ages_i[2*w +: 2];
    assign ages_o[2*w +: 2] = (way_i == WAY_W'(w)) ? 2'b00 :
                              (cur < pivot)         ? cur + 2'b01 : cur;
  end
endmodule

// File: rtl/l2t_victim_sel.sv
module l2t_victim_sel
  import l2t_pkg::*;
(
  input  logic [4*WAYS-1:0] pairs_i,
  input  logic [AGES_W-1:0] ages_i,
  output logic [WAY_W-1:0]  victim_o
);
  logic             free_any;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] old_way;

  always_comb begin
    free_any = 1'b0;
    free_way = '0;
    old_way  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (pairs_i[4*w +: 4] == 4'b0000) begin
        free_any = 1'b1;
        free_way = WAY_W'(w);
      end
      if (ages_i[2*w +: 2] == 2'b11) old_way = WAY_W'(w);
    end
    victim_o = free_any ? free_way : old_way;
  end
endmodule

// File: rtl/l2t_data_ram.sv
module l2t_data_ram
  import l2t_pkg::*;
#(
  parameter int SET_BITS = 4
) (
  input  logic                         clk,
  input  logic                         we,
  input  logic [WAY_W+SET_BITS+3:0]    addr,
  input  logic [31:0]                  wdata,
  output logic [31:0]                  rdata
);
  localparam int DEPTH = WAYS * (2 ** SET_BITS) * 16;

  logic [31:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/l2t_array.sv
module l2t_array
  import l2t_pkg::*;
#(
  parameter int SET_BITS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tp_en,
  input  logic        tp_we,
  input  logic [31:0] tp_loc,
  input  logic [31:0] tp_wdata,
  output logic [31:0] tp_rdata,
  input  logic        lk_en,
  input  logic [31:0] lk_addr,
  input  logic        lk_alloc,
  input  logic [1:0]  lk_fill,
  output logic        lk_ack,
  output logic        lk_hit,
  output logic [1:0]  lk_way,
  output logic [1:0]  lk_state
);
  localparam int SETS = 2 ** SET_BITS;
  localparam int DA_W = WAY_W + SET_BITS + 4;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ok = rsync_q[1];

  // storage
  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  pair_t             st_q  [SETS][WAYS];
  logic [AGES_W-1:0] age_q [SETS];

  logic [AGES_W-1:0] age_init;
  always_comb begin
    for (int w = 0; w < WAYS; w++) age_init[2*w +: 2] = 2'(w);
  end

  // test-port decode
  logic                tp_tag_sel, tp_tag_wr, tp_dat_wr, tp_rd;
  logic [WAY_W-1:0]    tp_way;
  logic [SET_BITS-1:0] tp_set;
  logic [DA_W-1:0]     da_addr;
  logic [31:0]         da_rdata;

  assign tp_tag_sel = tp_loc[SEL_BIT];
  assign tp_way     = tp_loc[WAY_LSB +: WAY_W];
  assign tp_set     = tp_loc[SET_LSB +: SET_BITS];
  assign tp_tag_wr  = tp_en && tp_we && tp_tag_sel;
  assign tp_dat_wr  = tp_en && tp_we && !tp_tag_sel;
  assign tp_rd      = tp_en && !tp_we;
  assign da_addr    = {tp_way, tp_set, tp_loc[LINE_BIT], tp_loc[OCT_LSB +: 2], tp_loc[DW_BIT]};

  l2t_data_ram #(.SET_BITS(SET_BITS)) u_data (
    .clk   (clk),
    .we    (tp_dat_wr),
    .addr  (da_addr),
    .wdata (tp_wdata),
    .rdata (da_rdata)
  );

  // lookup decode and compare
  logic [TAG_W-1:0]    lk_tag;
  logic [SET_BITS-1:0] lk_set;
  logic                lk_line;
  logic [4*WAYS-1:0]   lk_pairs;
  logic [AGES_W-1:0]   lk_ages;
  logic [WAYS-1:0]     sect_match, line_hit;
  logic [1:0]          line_st [WAYS];

  assign lk_tag  = lk_addr[TAG_LSB +: TAG_W];
  assign lk_set  = lk_addr[SET_LSB +: SET_BITS];
  assign lk_line = lk_addr[LINE_BIT];
  assign lk_ages = age_q[lk_set];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    pair_t p;
    assign p                = st_q[lk_set][w];
    assign lk_pairs[4*w +: 4] = p;
    assign sect_match[w]    = (tag_q[lk_set][w] == lk_tag) && (p != 4'b0000);
    assign line_st[w]       = lk_line ? p.l1 : p.l0;
    assign line_hit[w]      = sect_match[w] && (line_st[w] != ST_I);
  end

  logic             hit_any, sect_any;
  logic [WAY_W-1:0] hit_way, sect_way;
  always_comb begin
    hit_any  = 1'b0;
    sect_any = 1'b0;
    hit_way  = '0;
    sect_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (line_hit[w])   begin hit_any  = 1'b1; hit_way  = WAY_W'(w); end
      if (sect_match[w]) begin sect_any = 1'b1; sect_way = WAY_W'(w); end
    end
  end

  logic [WAY_W-1:0] victim;
  l2t_victim_sel u_victim (
    .pairs_i  (lk_pairs),
    .ages_i   (lk_ages),
    .victim_o (victim)
  );

  logic [WAY_W-1:0]  alloc_way, touch_way;
  logic [AGES_W-1:0] age_new;
  logic              touch, clash, lk_commit, fill_do;
  pair_t             old_pair, fill_pair;

  assign alloc_way = sect_any ? sect_way : victim;
  assign touch_way = hit_any ? hit_way : alloc_way;
  assign touch     = lk_en && (hit_any || lk_alloc);
  assign clash     = tp_tag_wr && (tp_set == lk_set);
  assign lk_commit = touch && !clash;
  assign fill_do   = lk_commit && !hit_any;
  assign old_pair  = st_q[lk_set][alloc_way];

  always_comb begin
    fill_pair = sect_any ? old_pair : '0;
    if (lk_line) fill_pair.l1 = lk_fill;
    else         fill_pair.l0 = lk_fill;
  end

  l2t_age_update u_age (
    .ages_i (lk_ages),
    .way_i  (touch_way),
    .ages_o (age_new)
  );

  // state and age registers
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      for (int s = 0; s < SETS; s++) begin
        age_q[s] <= age_init;
        for (int w = 0; w < WAYS; w++) st_q[s][w] <= '0;
      end
    end else begin
      if (tp_tag_wr) begin
        st_q[tp_set][tp_way] <= tp_wdata[11:8];
        age_q[tp_set]        <= tp_wdata[AGES_W-1:0];
      end
      if (lk_commit) begin
        age_q[lk_set] <= age_new;
        if (fill_do) st_q[lk_set][alloc_way] <= fill_pair;
      end
    end
  end

  // tags carry no reset: validity lives in the state bits
  always_ff @(posedge clk) begin
    if (tp_tag_wr) tag_q[tp_set][tp_way]  <= tp_wdata[TAG_LSB +: TAG_W];
    if (fill_do)   tag_q[lk_set][alloc_way] <= lk_tag;
  end

  // output next-state
  logic [31:0] rdata_d;
  logic        hit_d;
  logic [1:0]  way_d, state_d;

  always_comb begin
    if (tp_tag_sel)
      rdata_d = {tag_q[tp_set][tp_way], 2'b00, st_q[tp_set][tp_way], age_q[tp_set]};
    else
      rdata_d = da_rdata;
    hit_d   = lk_en && hit_any;
    way_d   = '0;
    state_d = ST_I;
    if (lk_en && hit_any) begin
      way_d   = hit_way;
      state_d = line_st[hit_way];
    end else if (lk_en && lk_alloc) begin
      way_d   = alloc_way;
      state_d = lk_fill;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      tp_rdata <= '0;
      lk_ack   <= 1'b0;
      lk_hit   <= 1'b0;
      lk_way   <= '0;
      lk_state <= ST_I;
    end else begin
      if (tp_rd) tp_rdata <= rdata_d;
      lk_ack   <= lk_en;
      lk_hit   <= hit_d;
      lk_way   <= way_d;
      lk_state <= state_d;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{lk_addr, tp_loc, tp_wdata[13:12]};
endmodule

// File: rtl/l2t_chk.sv
module l2t_chk (
  input logic        clk,
  input logic        rst_ok,
  input logic        tp_en,
  input logic        tp_we,
  input logic [31:0] tp_rdata,
  input logic        lk_en,
  input logic        lk_alloc,
  input logic [1:0]  lk_fill,
  input logic        lk_ack,
  input logic        lk_hit,
  input logic [1:0]  lk_way,
  input logic [1:0]  lk_state
);
  // R11
  ack_follows_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    lk_en |=> lk_ack);

  // R11
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !lk_en |=> !lk_ack);

  // R4
  hit_state_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    lk_hit |-> (lk_ack && lk_state != 2'b00));

  // R6
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (lk_en && !lk_alloc) |=> (lk_hit || (lk_state == 2'b00 && lk_way == 2'b00)));

  // R7
  alloc_state_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (lk_en && lk_alloc) |=> (lk_hit || lk_state == $past(lk_fill)));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !(tp_en && !tp_we) |=> $stable(tp_rdata));
endmodule

bind l2t_array l2t_chk u_chk (
  .clk      (clk),
  .rst_ok   (rst_ok),
  .tp_en    (tp_en),
  .tp_we    (tp_we),
  .tp_rdata (tp_rdata),
  .lk_en    (lk_en),
  .lk_alloc (lk_alloc),
  .lk_fill  (lk_fill),
  .lk_ack   (lk_ack),
  .lk_hit   (lk_hit),
  .lk_way   (lk_way),
  .lk_state (lk_state)
);

// File: tb/tb_l2t_array.sv
module tb_l2t_array;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tp_en = 1'b0, tp_we = 1'b0;
  logic [31:0] tp_loc = '0, tp_wdata = '0;
  logic [31:0] tp_rdata;
  logic        lk_en = 1'b0, lk_alloc = 1'b0;
  logic [31:0] lk_addr = '0;
  logic [1:0]  lk_fill = '0;
  logic        lk_ack, lk_hit;
  logic [1:0]  lk_way, lk_state;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  l2t_array dut (.*);

  function automatic logic [31:0] tloc(int way, int set);
    return (32'd1 << 20) | (32'(way) << 16) | (32'(set) << 6);
  endfunction
  function automatic logic [31:0] dloc(int way, int set, int line, int oct, int dw);
    return (32'(way) << 16) | (32'(set) << 6) | (32'(line) << 5) | (32'(oct) << 3) | (32'(dw) << 2);
  endfunction
  function automatic logic [31:0] laddr(int tag, int set, int line);
    return (32'(tag) << 14) | (32'(set) << 6) | (32'(line) << 5);
  endfunction
  function automatic logic [31:0] tw(int tag, int l1, int l0, int ages);
    return (32'(tag) << 14) | (32'(l1) << 10) | (32'(l0) << 8) | 32'(ages);
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic tp_wr(logic [31:0] loc, logic [31:0] d);
    tp_en = 1; tp_we = 1; tp_loc = loc; tp_wdata = d;
    @(negedge clk);
    tp_en = 0; tp_we = 0;
  endtask

  task automatic tp_rd(logic [31:0] loc, output logic [31:0] d);
    tp_en = 1; tp_we = 0; tp_loc = loc;
    @(negedge clk);
    d = tp_rdata;
    tp_en = 0;
  endtask

  task automatic look(logic [31:0] a, logic al, logic [1:0] f,
                      output logic h, output logic [1:0] w, output logic [1:0] s);
    lk_en = 1; lk_addr = a; lk_alloc = al; lk_fill = f;
    @(negedge clk);
    h = lk_hit; w = lk_way; s = lk_state;
    chk("R11 ack", 32'(lk_ack), 32'd1);
    lk_en = 0; lk_alloc = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic h; logic [1:0] w, s;
    tp_rd(tloc(2, 3), d);
    chk("R1 state/age after reset", d & 32'h3FFF, 32'h00E4);
    look(laddr(0, 3, 0), 0, 0, h, w, s);
    chk("R1 miss after reset", {h, w, s}, 5'b0);
  endtask

  task automatic t_tag_port;
    logic [31:0] d, keep;
    tp_wr(tloc(1, 5), tw(32'h2ABCD, 3, 1, 8'hE4));
    tp_rd(tloc(1, 5), d);
    chk("R2 tag word readback", d, tw(32'h2ABCD, 3, 1, 8'hE4));
    tp_rd(tloc(0, 5), d);
    chk("R2 other way untouched", d & 32'h3FFF, 32'h00E4);
    keep = d;
    @(negedge clk);
    chk("R11 idle ack low", 32'(lk_ack), 32'd0);
    tp_wr(tloc(3, 6), tw(1, 1, 1, 8'hE4));
    chk("R11 rdata holds", tp_rdata, keep);
  endtask

  task automatic t_data;
    logic [31:0] d;
    tp_wr(dloc(2, 7, 1, 3, 1), 32'hDEADBEEF);
    tp_wr(dloc(2, 7, 1, 3, 0), 32'h12345678);
    tp_wr(dloc(2, 7, 0, 3, 1), 32'hCAFEF00D);
    tp_rd(dloc(2, 7, 1, 3, 1), d); chk("R3 upper dword", d, 32'hDEADBEEF);
    tp_rd(dloc(2, 7, 1, 3, 0), d); chk("R3 lower dword", d, 32'h12345678);
    tp_rd(dloc(2, 7, 0, 3, 1), d); chk("R3 line0", d, 32'hCAFEF00D);
  endtask

  task automatic t_hit;
    logic [31:0] d; logic h; logic [1:0] w, s;
    look(laddr(32'h2ABCD, 5, 1), 0, 0, h, w, s);
    chk("R4 hit line1 M", {h, w, s}, {1'b1, 2'd1, 2'b11});
    tp_rd(tloc(1, 5), d);
    chk("R5 ages after hit", d, tw(32'h2ABCD, 3, 1, 8'hE1));
    look(laddr(32'h2ABCD, 5, 0), 0, 0, h, w, s);
    chk("R4 hit line0 S", {h, w, s}, {1'b1, 2'd1, 2'b01});
  endtask

  task automatic t_miss;
    logic [31:0] d; logic h; logic [1:0] w, s;
    look(laddr(32'h11111, 5, 0), 0, 2'b10, h, w, s);
    chk("R6 miss outputs", {h, w, s}, 5'b0);
    tp_rd(tloc(1, 5), d);
    chk("R6 ages unchanged", d, tw(32'h2ABCD, 3, 1, 8'hE1));
  endtask

  task automatic t_alloc_free;
    logic [31:0] d; logic h; logic [1:0] w, s;
    look(laddr(32'h11111, 5, 0), 1, 2'b10, h, w, s);
    chk("R7 alloc free way", {h, w, s}, {1'b0, 2'd0, 2'b10});
    tp_rd(tloc(0, 5), d);
    chk("R7 filled entry", d, tw(32'h11111, 0, 2, 8'hE4));
  endtask

  task automatic t_alloc_age;
    logic [31:0] d; logic h; logic [1:0] w, s;
    for (int k = 0; k < 4; k++) tp_wr(tloc(k, 9), tw(32'h100 + k, 1, 1, 8'h39));
    look(laddr(32'h3FFFF, 9, 1), 1, 2'b11, h, w, s);
    chk("R7 oldest way victim", {h, w, s}, {1'b0, 2'd2, 2'b11});
    tp_rd(tloc(2, 9), d);
    chk("R7 replaced entry", d, tw(32'h3FFFF, 3, 0, 8'h4E));
  endtask

  task automatic t_sector;
    logic [31:0] d; logic h; logic [1:0] w, s;
    look(laddr(32'h11111, 5, 1), 1, 2'b01, h, w, s);
    chk("R8 sector reuse", {h, w, s}, {1'b0, 2'd0, 2'b01});
    tp_rd(tloc(0, 5), d);
    chk("R8 other line kept", d, tw(32'h11111, 1, 2, 8'hE4));
  endtask

  task automatic t_raw_ages;
    logic [31:0] d;
    tp_wr(tloc(3, 12), tw(5, 0, 0, 8'hFF));
    tp_rd(tloc(3, 12), d);
    chk("R9 raw ages kept", d, tw(5, 0, 0, 8'hFF));
  endtask

  task automatic t_clash;
    logic [31:0] d; logic h; logic [1:0] w, s;
    // same set: lookup hit on way 1 and tag write to way 2 of set 5
    lk_en = 1; lk_addr = laddr(32'h2ABCD, 5, 1); lk_alloc = 0;
    tp_en = 1; tp_we = 1; tp_loc = tloc(2, 5); tp_wdata = tw(32'h07777, 0, 2, 8'h1B);
    @(negedge clk);
    chk("R10 same-set lookup result", {lk_hit, lk_way, lk_state}, {1'b1, 2'd1, 2'b11});
    lk_en = 0; tp_en = 0; tp_we = 0;
    tp_rd(tloc(2, 5), d); chk("R10 test write stored", d, tw(32'h07777, 0, 2, 8'h1B));
    tp_rd(tloc(1, 5), d); chk("R10 lookup update dropped", d, tw(32'h2ABCD, 3, 1, 8'h1B));
    // different sets: both take effect
    lk_en = 1; lk_addr = laddr(32'h100, 9, 0);
    tp_en = 1; tp_we = 1; tp_loc = tloc(0, 12); tp_wdata = tw(32'h22, 0, 0, 8'h1B);
    @(negedge clk);
    chk("R10 other-set lookup result", {lk_hit, lk_way, lk_state}, {1'b1, 2'd0, 2'b01});
    lk_en = 0; tp_en = 0; tp_we = 0;
    tp_rd(tloc(0, 9), d);  chk("R10 lookup ages applied", d, tw(32'h100, 1, 1, 8'h9C));
    tp_rd(tloc(0, 12), d); chk("R10 write applied", d, tw(32'h22, 0, 0, 8'h1B));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset;
    t_tag_port;
    t_data;
    t_hit;
    t_miss;
    t_alloc_free;
    t_alloc_age;
    t_sector;
    t_raw_ages;
    t_clash;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired before all requirement checks ran");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule